// File: doc/BRIEF.md
# Dual-Rate Display Shift-Out Engine

This block drives one shared serial line (clock plus data) that feeds two kinds of receivers in an LED display. At the start of every bit cycle it sends the 32-bit column word for the current bit plane and segment. The word goes out as two back-to-back 16-bit frames at the fast serial rate. Once per segment it sends a 16-bit auxiliary word at half that rate. The auxiliary word goes to slower shift registers that select the active segment, set the LED current level and light the status LEDs. The block forms this word itself from the segment index, a brightness flag and three status bits. It also drives the auxiliary latch strobe.

The bit and segment timing is set outside the block, which only reacts to request pulses. The serial clock idles high, and data changes on the falling edge so that the receiver samples it on the rising edge. A request that arrives while a transfer is running is held in a single waiting slot. The `busy` output tells the timing logic when the line is free again.

Top module: `disp_shift_engine`

## Requirements
- R1: An LED word is shifted as 32 bits, most significant bit first, so bits 31:16 form the first 16-bit frame and bits 15:0 the second, with no gap between them.
- R2: `sclk` is high whenever no transfer is running. `mosi` changes only together with a falling edge of `sclk` and holds steady while `sclk` is high.
- R3: LED-word bits use a serial clock period of 2 `clk` cycles (1 low, 1 high). Auxiliary-word bits use 4 `clk` cycles (2 low, 2 high).
- R4: Auxiliary bits 15:8 are all 1 except bit 8+p, which is 0. Here p is the physical position of logical segment `seg_idx` under the map 0→5, 1→7, 2→6, 3→4, 4→1, 5→3, 6→0, 7→2.
- R5: Auxiliary bit 7 equals `bright` and bit 6 equals its inverse. Bits 5:4 and bit 0 are 0.
- R6: Auxiliary bit 1 is `stat_comm`, bit 2 is `stat_err` and bit 3 is `stat_id`. All auxiliary inputs are captured in the cycle `aux_req` is high.
- R7: `aux_strobe` is 1 after reset. It drops to 0 in the cycle after an auxiliary transfer begins, and returns to 1 in the cycle after an `led_req` pulse. If both events fall in the same cycle, the drop wins.
- R8: `busy` rises in the cycle after an accepted request. It falls 1 `clk` cycle (fast rate) or 2 `clk` cycles (slow rate) after the last rising `sclk` edge, unless a request is waiting.
- R9: A request that arrives while busy is held in a one-entry slot and sent as soon as the current transfer ends. Requests that arrive while the slot is full are dropped. When `led_req` and `aux_req` arrive together, the LED word is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| led_req | input | 1 | One-cycle pulse: bit cycle starts, send `led_word` |
| led_word | input | 32 | LED column word for the current plane and segment |
| aux_req | input | 1 | One-cycle pulse: send a freshly built auxiliary word |
| seg_idx | input | 3 | Logical segment index for the select field |
| bright | input | 1 | 1 selects high LED current, 0 low |
| stat_comm | input | 1 | Communication status LED |
| stat_err | input | 1 | Error status LED |
| stat_id | input | 1 | Identify status LED |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data, MSB first |
| aux_strobe | output | 1 | Auxiliary register latch strobe |
| busy | output | 1 | Transfer running or waiting |

## Verification
The hardest situation to reach is a full waiting slot with a third request arriving while the slot's own entry is still blocked. Only then is the drop path exercised and the strobe ordering put under stress. The bench gets there by sending `led_req`, `aux_req` and `led_req` again on three consecutive cycles. It then checks that exactly 48 bits arrive (LED then auxiliary), that nothing follows, and that the strobe ends low. A second case fires both requests in one cycle to exercise the priority rule and the handoff from the slot without a gap in `busy`.

// File: rtl/dse_pkg.sv
package dse_pkg;
    localparam int LED_W   = 32;
    localparam int FRAME_W = 16;
    localparam int SEG_N   = 8;
    localparam int SEG_W   = $clog2(SEG_N);
    localparam int SEL_W   = SEG_N;

    // Logical segment index to physical select line.
    function automatic logic [SEG_W-1:0] seg_phys(input logic [SEG_W-1:0] l);
        logic [SEG_W-1:0] p;
        case (l)
            3'd0: p = 3'd5;
            3'd1: p = 3'd7;
            3'd2: p = 3'd6;
            3'd3: p = 3'd4;
            3'd4: p = 3'd1;
            3'd5: p = 3'd3;
            3'd6: p = 3'd0;
            default: p = 3'd2;
        endcase
        return p;
    endfunction

    typedef struct packed {
        logic             v;
        logic             aux;
        logic [LED_W-1:0] word;
    } dse_req_t;
endpackage

// File: rtl/dse_aux_format.sv
module dse_aux_format
    import dse_pkg::*;
(
    input  logic [SEG_W-1:0]   seg_idx,
    input  logic               bright,
    input  logic               stat_comm,
    input  logic               stat_err,
    input  logic               stat_id,
    output logic [FRAME_W-1:0] aux_word
);
    logic [SEL_W-1:0] sel_hot;

    always_comb begin
        sel_hot  = SEL_W'(1) << seg_phys(seg_idx);
        aux_word = {~sel_hot, bright, ~bright, 2'b00,
                    stat_id, stat_err, stat_comm, 1'b0};
    end
endmodule

// File: rtl/dse_req_queue.sv
module dse_req_queue
    import dse_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               led_req,
    input  logic [LED_W-1:0]   led_word,
    input  logic               aux_req,
    input  logic [FRAME_W-1:0] aux_word,
    input  logic               ser_busy,
    output logic               go,
    output logic               go_aux,
    output logic [LED_W-1:0]   go_word,
    output logic               pend
);
    localparam int PAD_W = LED_W - FRAME_W;

    dse_req_t slot_d, slot_q;
    dse_req_t first, second;

    always_comb begin
        first.v     = led_req | aux_req;
        first.aux   = ~led_req;
        first.word  = led_req ? led_word : {aux_word, {PAD_W{1'b0}}};
        second.v    = led_req & aux_req;
        second.aux  = 1'b1;
        second.word = {aux_word, {PAD_W{1'b0}}};

        slot_d  = slot_q;
        go      = 1'b0;
        go_aux  = 1'b0;
        go_word = '0;
        if (!ser_busy) begin
            if (slot_q.v) begin
                go      = 1'b1;
                go_aux  = slot_q.aux;
                go_word = slot_q.word;
                slot_d  = first;
            end else if (first.v) begin
                go      = 1'b1;
                go_aux  = first.aux;
                go_word = first.word;
                slot_d  = second;
            end
        end else if (!slot_q.v) begin
            slot_d = first;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign pend = slot_q.v;

    // R9: a waiting entry survives untouched while the line is busy
    p_slot_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.v && ser_busy) |=> (slot_q.v && $stable(slot_q.word)));
endmodule

// File: rtl/dse_serializer.sv
module dse_serializer
    import dse_pkg::*;
#(
    parameter int HALF_FAST = 1,
    parameter int HALF_SLOW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             go_aux,
    input  logic [LED_W-1:0] go_word,
    output logic             sclk,
    output logic             mosi,
    output logic             active
);
    localparam int HMAX   = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int CNT_W  = $clog2(HMAX + 1);
    localparam int LEFT_W = $clog2(LED_W);

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic              slow;
        logic [CNT_W-1:0]  cnt;
        logic [LEFT_W-1:0] left;
        logic [LED_W-1:0]  sh;
    } ser_t;

    ser_t s_d, s_q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        s_d     = s_q;
        half_m1 = s_q.slow ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.sclk   = 1'b0;
                s_d.slow   = go_aux;
                s_d.cnt    = '0;
                s_d.left   = go_aux ? LEFT_W'(FRAME_W - 1) : LEFT_W'(LED_W - 1);
                s_d.sh     = go_word;
            end
        end else if (s_q.cnt == half_m1) begin
            s_d.cnt = '0;
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
            end else if (s_q.left == '0) begin
                s_d.active = 1'b0;
            end else begin
                s_d.sclk = 1'b0;
                s_d.sh   = {s_q.sh[LED_W-2:0], 1'b0};
                s_d.left = s_q.left - 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sclk <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk   = s_q.sclk;
    assign mosi   = s_q.sh[LED_W-1];
    assign active = s_q.active;

    // R2: clock rests high between transfers
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> s_q.sclk);
    // R2: data only moves with a falling clock edge
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && $past(s_q.active) && !$fell(s_q.sclk)) |-> $stable(mosi));
endmodule

// File: rtl/disp_shift_engine.sv
module disp_shift_engine
    import dse_pkg::*;
#(
    parameter int HALF_FAST = 1,
    parameter int HALF_SLOW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             led_req,
    input  logic [31:0]      led_word,
    input  logic             aux_req,
    input  logic [2:0]       seg_idx,
    input  logic             bright,
    input  logic             stat_comm,
    input  logic             stat_err,
    input  logic             stat_id,
    output logic             sclk,
    output logic             mosi,
    output logic             aux_strobe,
    output logic             busy
);
    logic [FRAME_W-1:0] aux_word;
    logic               go, go_aux, pend, active;
    logic [LED_W-1:0]   go_word;

    typedef struct packed {
        logic strobe;
    } top_t;
    top_t t_d, t_q;

    dse_aux_format u_fmt (
        .seg_idx  (seg_idx),
        .bright   (bright),
        .stat_comm(stat_comm),
        .stat_err (stat_err),
        .stat_id  (stat_id),
        .aux_word (aux_word)
    );

    dse_req_queue u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .led_req (led_req),
        .led_word(led_word),
        .aux_req (aux_req),
        .aux_word(aux_word),
        .ser_busy(active),
        .go      (go),
        .go_aux  (go_aux),
        .go_word (go_word),
        .pend    (pend)
    );

    dse_serializer #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .go_aux (go_aux),
        .go_word(go_word),
        .sclk   (sclk),
        .mosi   (mosi),
        .active (active)
    );

    always_comb begin
        t_d = t_q;
        if (go && go_aux)  t_d.strobe = 1'b0;
        else if (led_req)  t_d.strobe = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q.strobe <= 1'b1;
        else        t_q        <= t_d;
    end

    assign aux_strobe = t_q.strobe;
    assign busy       = active | pend;

    // R4: exactly one select line is low
    p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(aux_word[15:8]) == 7);
    // R5: current level bits are complementary
    p_cur_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        aux_word[7] != aux_word[6]);
    // R7: strobe only drops when a transfer is under way
    p_strobe_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aux_strobe) |-> busy);
    // R7: strobe only rises after a bit-cycle start
    p_strobe_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_strobe) |-> $past(led_req));
endmodule

// File: tb/sim_disp_shift_engine.sv
module sim_disp_shift_engine;
    localparam int CLK_PERIOD = 20;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        led_req = 1'b0, aux_req = 1'b0;
    logic [31:0] led_word = '0;
    logic [2:0]  seg_idx = '0;
    logic        bright = 1'b0, stat_comm = 1'b0, stat_err = 1'b0, stat_id = 1'b0;
    logic        sclk, mosi, aux_strobe, busy;

    int checks = 0, errors = 0;
    int cyc = 0, wd = 0;
    logic [63:0] rx_bits;
    int rx_n, last_rise, per_min, per_max, fall_gap;
    int hold_viol = 0, idle_viol = 0;
    logic sclk_prev = 1'b1, mosi_prev = 1'b0, busy_prev = 1'b0;

    disp_shift_engine u0 (
        .clk(clk), .rst_n(rst_n), .led_req(led_req), .led_word(led_word),
        .aux_req(aux_req), .seg_idx(seg_idx), .bright(bright),
        .stat_comm(stat_comm), .stat_err(stat_err), .stat_id(stat_id),
        .sclk(sclk), .mosi(mosi), .aux_strobe(aux_strobe), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // serial receiver and line monitor
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (sclk && !sclk_prev) begin
                rx_bits = {rx_bits[62:0], mosi};
                rx_n = rx_n + 1;
                if (last_rise >= 0) begin
                    if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                    if (cyc - last_rise > per_max) per_max = cyc - last_rise;
                end
                last_rise = cyc;
            end
            if (sclk && sclk_prev && mosi !== mosi_prev) hold_viol = hold_viol + 1;
            if (!busy && !sclk) idle_viol = idle_viol + 1;
            if (busy_prev && !busy) fall_gap = cyc - last_rise;
        end
        sclk_prev = sclk;
        mosi_prev = mosi;
        busy_prev = busy;
    end

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > WD_LIMIT) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL R8 watchdog: busy never cleared, act=%0d exp=<%0d cycles", wd, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] aux_exp(input logic [2:0] s, input logic b,
                                            input logic c, input logic e, input logic i);
        int phys [8] = '{5, 7, 6, 4, 1, 3, 0, 2};
        logic [7:0] sel;
        sel = 8'hFF & ~(8'h01 << phys[s]);
        return {sel, b, ~b, 2'b00, i, e, c, 1'b0};
    endfunction

    task automatic rx_clear();
        rx_bits = '0; rx_n = 0; last_rise = -1;
        per_min = 1000; per_max = 0; fall_gap = -1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_led(input logic [31:0] w);
        @(negedge clk); led_req = 1'b1; led_word = w;
        @(negedge clk); led_req = 1'b0;
    endtask

    task automatic set_aux(input logic [2:0] s, input logic b, input logic c,
                           input logic e, input logic i);
        seg_idx = s; bright = b; stat_comm = c; stat_err = e; stat_id = i;
    endtask

    task automatic t_reset();
        chk(aux_strobe == 1'b1, "R7 strobe after reset", aux_strobe, 1);
        chk(busy == 1'b0, "R8 busy after reset", busy, 0);
        chk(sclk == 1'b1, "R2 sclk idle after reset", sclk, 1);
    endtask

    task automatic t_led(input logic [31:0] w);
        rx_clear();
        pulse_led(w);
        chk(busy == 1'b1, "R8 busy after led_req", busy, 1);
        wait_idle();
        chk(rx_n == 32, "R1 led bit count", rx_n, 32);
        chk(rx_bits[31:0] == w, "R1 led word order", rx_bits[31:0], w);
        chk(per_min == 2 && per_max == 2, "R3 fast period", per_max, 2);
        chk(fall_gap == 1, "R8 busy fall fast", fall_gap, 1);
    endtask

    task automatic t_aux(input logic [2:0] s, input logic b, input logic c,
                         input logic e, input logic i);
        logic [15:0] exp;
        exp = aux_exp(s, b, c, e, i);
        rx_clear();
        @(negedge clk); set_aux(s, b, c, e, i); aux_req = 1'b1;
        @(negedge clk); aux_req = 1'b0; set_aux(~s, ~b, ~c, ~e, ~i);
        chk(aux_strobe == 1'b0, "R7 strobe low after aux start", aux_strobe, 0);
        wait_idle();
        chk(rx_n == 16, "R4 aux bit count", rx_n, 16);
        chk(rx_bits[15:8] == exp[15:8], "R4 segment select", rx_bits[15:8], exp[15:8]);
        chk(rx_bits[7:0] == exp[7:0], "R5/R6 current and status bits", rx_bits[7:0], exp[7:0]);
        chk(per_min == 4 && per_max == 4, "R3 slow period", per_max, 4);
        chk(fall_gap == 2, "R8 busy fall slow", fall_gap, 2);
        chk(aux_strobe == 1'b0, "R7 strobe held until bit cycle", aux_strobe, 0);
        rx_clear();
        pulse_led(32'h0000_0001);
        chk(aux_strobe == 1'b1, "R7 strobe release on led_req", aux_strobe, 1);
        wait_idle();
    endtask

    task automatic t_queue();
        logic [15:0] exp;
        exp = aux_exp(3'd6, 1'b1, 1'b0, 1'b1, 1'b0);
        rx_clear();
        @(negedge clk); led_req = 1'b1; led_word = 32'hCAFE_0F0F;
        @(negedge clk); led_req = 1'b0; aux_req = 1'b1; set_aux(3'd6, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk); aux_req = 1'b0; led_req = 1'b1; led_word = 32'hFFFF_FFFF;
        @(negedge clk); led_req = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(rx_n == 48, "R9 queued total, third dropped", rx_n, 48);
        chk(rx_bits[47:16] == 32'hCAFE_0F0F, "R9 first transfer", rx_bits[47:16], 32'hCAFE_0F0F);
        chk(rx_bits[15:0] == exp, "R9 queued aux word", rx_bits[15:0], exp);
        chk(aux_strobe == 1'b0, "R7 strobe low after queued aux", aux_strobe, 0);
        chk(fall_gap == 2, "R8 busy spans queued transfer", fall_gap, 2);
    endtask

    task automatic t_simul();
        logic [15:0] exp;
        exp = aux_exp(3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        rx_clear();
        @(negedge clk); led_req = 1'b1; aux_req = 1'b1; led_word = 32'h1234_8001;
        set_aux(3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk); led_req = 1'b0; aux_req = 1'b0;
        wait_idle();
        chk(rx_n == 48, "R9 both requests sent", rx_n, 48);
        chk(rx_bits[47:16] == 32'h1234_8001, "R9 led first", rx_bits[47:16], 32'h1234_8001);
        chk(rx_bits[15:0] == exp, "R9 aux second", rx_bits[15:0], exp);
        chk(aux_strobe == 1'b0, "R7 drop wins after led release", aux_strobe, 0);
    endtask

    initial begin
        rx_clear();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_led(32'hA5C3_0001);
        t_led(32'h8000_FFFE);
        t_led(32'h0000_0000);
        t_aux(3'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        t_aux(3'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        t_aux(3'd7, 1'b1, 1'b0, 1'b0, 1'b1);
        t_aux(3'd4, 1'b0, 1'b1, 1'b1, 1'b0);
        t_queue();
        t_simul();
        chk(hold_viol == 0, "R2 data steady while sclk high", hold_viol, 0);
        chk(idle_viol == 0, "R2 sclk high when idle", idle_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule